// File: doc/BRIEF.md
# Piecewise-Quadratic Reciprocal and Root Evaluator

The block is a pipelined fixed-point unit for three functions of a normalized mantissa: the reciprocal, the square root and the inverse square root. A two-bit code selects the function. For the two root functions, one more input bit gives the parity of the exponent. When that bit is set, the block evaluates the function at twice the mantissa, so that a caller can produce a full floating-point root by halving the exponent alone.

The mantissa range is split into 128 equal segments. For each segment and each table region, a single read-only table holds three coefficients of a quadratic. There are five regions: the reciprocal, and the even and odd exponent halves of each root function. The coefficients are computed while the design elaborates. The low mantissa bits form the offset t inside the segment, and the block evaluates c0 + t·(c1 + t·c2) in nested form. It uses two unsigned multiplies, each no larger than 24×17, and adders no wider than 48 bits. Every intermediate value is truncated.

The block accepts one operand per clock and returns one result per clock, in input order. Exponent arithmetic, special operands and any refinement step belong to the caller.

Top module: `fpe_poly_eval`

## Requirements
- R1: While reset is asserted, and after it is released with no valid input yet, valid_o is 0 and result_o is 0.
- R2: A valid input sampled on a rising edge produces valid_o high, with its result, right after the fourth rising edge counted from the sampling edge. The block accepts one input every cycle and returns results in input order. valid_o is high only for such inputs.
- R3: The operand is m = 1 + mant_i·2^-23 and the result is result_o·2^-27. For func_i = 0 (reciprocal), the result is within 2^-23 of 1/m.
- R4: For func_i = 1 (square root), the result is within 2^-23 of sqrt(m) when odd_exp_i = 0, and within 2^-23 of sqrt(2m) when odd_exp_i = 1.
- R5: For func_i = 2 (inverse square root), the result is within 2^-23 of 1/sqrt(m) when odd_exp_i = 0, and within 2^-23 of 1/sqrt(2m) when odd_exp_i = 1.
- R6: Segments are selected by mant_i[22:16] and the offset is mant_i[15:0]. The bound of R3 to R5 holds at both ends of every segment, offset 0 and offset 16'hFFFF, in all five table regions.
- R7: When mant_i = 0 and odd_exp_i = 0, all three functions return exactly 1.0 (result_o = 28'h8000000).
- R8: For the reciprocal, odd_exp_i has no effect on the result. The code func_i = 3 gives a result bit-identical to func_i = 0.
- R9: result_o keeps its last value on every cycle where valid_o is 0.
- R10: The intermediate accumulations never wrap. The linear coefficient minus the quadratic correction stays non-negative, and the final sum or difference stays inside the 28-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| func_i | input | 2 | 0 reciprocal, 1 square root, 2 inverse square root, 3 reciprocal |
| odd_exp_i | input | 1 | Root functions: evaluate at 2m instead of m |
| mant_i | input | 23 | Mantissa fraction bits; m = 1 + mant_i·2^-23 |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | 28 | Result, unsigned with 1 integer and 27 fraction bits |

## Verification
The main sweep covers every segment of all five table regions at three offsets: the segment start, the segment end and the midpoint. The start and end offsets separate a fault in the constant or linear coefficient from a fault in the curvature term, which matters most at the far end of a segment. A dense random stream of mixed functions with occasional idle gaps shows whether results stay in order, keep their four-edge latency and hold between bursts. Triplets of the same mantissa, sent as reciprocal with both parity values and as code 3, show whether the parity bit or the alias code leaks into the reciprocal path. Unit operands check the exact 1.0 result.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int FRAC_W  = 23;
  localparam int IDX_W   = 7;
  localparam int OFF_W   = FRAC_W - IDX_W;
  localparam int FN_W    = 2;
  localparam int REG_N   = 5;
  localparam int REG_W   = $clog2(REG_N);
  localparam int DEPTH   = REG_N << IDX_W;
  localparam int ADDR_W  = REG_W + IDX_W;

  localparam int C0_F    = 25;
  localparam int C0_W    = C0_F + 1;
  localparam int C1_F    = 19;
  localparam int C1_W    = C1_F;
  localparam int C2_F    = 11;
  localparam int C2_W    = C2_F;
  localparam int WORD_W  = C0_W + C1_W + C2_W;

  localparam int Q1_F    = 23;
  localparam int Q1_W    = Q1_F;
  localparam int RES_F   = 27;
  localparam int RES_W   = RES_F + 1;

  localparam int P1_W    = C2_W + OFF_W;
  localparam int P1_SH   = C2_F + FRAC_W - Q1_F;
  localparam int P2_W    = Q1_W + OFF_W;
  localparam int P2_SH   = Q1_F + FRAC_W - RES_F;

  localparam int SCALE   = 48;
  localparam int ARG_U   = IDX_W + 1;

  localparam logic [FN_W-1:0] FN_RECIP = 2'd0;
  localparam logic [FN_W-1:0] FN_SQRT  = 2'd1;
  localparam logic [FN_W-1:0] FN_RSQRT = 2'd2;

  typedef struct packed {
    logic [C2_W-1:0] c2;
    logic [C1_W-1:0] c1;
    logic [C0_W-1:0] c0;
  } coef_t;

  function automatic logic [127:0] isqrt128(input logic [127:0] n);
    logic [127:0] r, t;
    r = '0;
    for (int b = 63; b >= 0; b--) begin
      t = r | (128'd1 << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // a is the argument in units of 2^-ARG_U; result scaled by 2^SCALE
  function automatic logic [127:0] fn_point(input int unsigned fsel, input logic [127:0] a);
    logic [127:0] v;
    case (fsel)
      0:       v = ((128'd1 << (SCALE + ARG_U)) + (a >> 1)) / a;
      1:       v = isqrt128(a << (2 * SCALE - ARG_U));
      default: v = isqrt128((128'd1 << (2 * SCALE + ARG_U)) / a);
    endcase
    return v;
  endfunction

  function automatic logic [127:0] rnd_shift(input logic [127:0] v, input int sh);
    return (v + (128'd1 << (sh - 1))) >> sh;
  endfunction

  // Quadratic through segment start, middle and end
  function automatic coef_t coef_word(input int unsigned entry);
    int unsigned region, idx, fsel;
    logic odd;
    logic [127:0] a0, f0, fm, f1, m1, m2, q0, q1, q2;
    coef_t w;
    region = entry >> IDX_W;
    idx    = entry & ((1 << IDX_W) - 1);
    fsel   = (region == 0) ? 0 : (region <= 2) ? 1 : 2;
    odd    = (region == 2) || (region == 4);
    a0     = 128'((1 << ARG_U) + 2 * idx);
    f0     = fn_point(fsel, odd ? (a0 << 1) : a0);
    fm     = fn_point(fsel, odd ? ((a0 + 1) << 1) : (a0 + 1));
    f1     = fn_point(fsel, odd ? ((a0 + 2) << 1) : (a0 + 2));
    if (fsel == 1) begin
      m1 = 4 * fm - 3 * f0 - f1;
      m2 = 2 * fm - f0 - f1;
    end else begin
      m1 = 3 * f0 + f1 - 4 * fm;
      m2 = f0 + f1 - 2 * fm;
    end
    q0 = rnd_shift(f0, SCALE - C0_F);
    q1 = rnd_shift(m1, SCALE - IDX_W - C1_F);
    q2 = rnd_shift(m2, SCALE - 2 * IDX_W - 1 - C2_F);
    if (q1 > 128'((1 << C1_W) - 1)) q1 = 128'((1 << C1_W) - 1);
    if (q2 > 128'((1 << C2_W) - 1)) q2 = 128'((1 << C2_W) - 1);
    w.c0 = q0[C0_W-1:0];
    w.c1 = q1[C1_W-1:0];
    w.c2 = q2[C2_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/fpe_coef_rom.sv
module fpe_coef_rom
  import fpe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output coef_t             data_o
);
  coef_t rom_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam coef_t ENT = coef_word(g);
    assign rom_w[g] = ENT;
  end

  always_ff @(posedge clk_i) begin
    if (en_i) data_o <= rom_w[addr_i];
  end

  assert_addr_in_table_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (int'(addr_i) < DEPTH));
endmodule

// File: rtl/fpe_quad_mac.sv
// q1 = |c1| - |c2|*t ; sign pattern of c1/c2 is opposite for all three functions
module fpe_quad_mac
  import fpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  coef_t            coef_i,
  input  logic [OFF_W-1:0] x_i,
  input  logic             neg_i,
  output logic             v_o,
  output logic [Q1_W-1:0]  q1_o,
  output logic [C0_W-1:0]  c0_o,
  output logic [OFF_W-1:0] x_o,
  output logic             neg_o
);
  logic [P1_W-1:0] p1_w;
  logic [Q1_W-1:0] p1_s, c1_e;

  assign p1_w = {{OFF_W{1'b0}}, coef_i.c2} * {{C2_W{1'b0}}, x_i};
  assign p1_s = Q1_W'(p1_w >> P1_SH);
  assign c1_e = {coef_i.c1, {(Q1_F - C1_F){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_o <= 1'b0;
    else         v_o <= v_i;
  end

  always_ff @(posedge clk_i) begin
    if (v_i) begin
      q1_o  <= c1_e - p1_s;
      c0_o  <= coef_i.c0;
      x_o   <= x_i;
      neg_o <= neg_i;
    end
  end

  assert_no_borrow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> (c1_e >= p1_s));
endmodule

// File: rtl/fpe_lin_mac.sv
// product register, then c0 +/- q1*t
module fpe_lin_mac
  import fpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [Q1_W-1:0]  q1_i,
  input  logic [C0_W-1:0]  c0_i,
  input  logic [OFF_W-1:0] x_i,
  input  logic             neg_i,
  output logic             v_o,
  output logic [RES_W-1:0] res_o
);
  logic             v_a_q;
  logic [P2_W-1:0]  p2_q;
  logic [C0_W-1:0]  c0_a_q;
  logic             neg_a_q;
  logic [RES_W-1:0] c0_e, p2_s;
  logic [RES_W:0]   sum_w;

  assign c0_e  = {c0_a_q, {(RES_F - C0_F){1'b0}}};
  assign p2_s  = RES_W'(p2_q >> P2_SH);
  assign sum_w = neg_a_q ? ({1'b0, c0_e} - {1'b0, p2_s}) : ({1'b0, c0_e} + {1'b0, p2_s});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_a_q <= 1'b0;
      v_o   <= 1'b0;
      res_o <= '0;
    end else begin
      v_a_q <= v_i;
      v_o   <= v_a_q;
      if (v_a_q) res_o <= sum_w[RES_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (v_i) begin
      p2_q    <= {{OFF_W{1'b0}}, q1_i} * {{Q1_W{1'b0}}, x_i};
      c0_a_q  <= c0_i;
      neg_a_q <= neg_i;
    end
  end

  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_a_q |-> (sum_w[RES_W] == 1'b0));
endmodule

// File: rtl/fpe_poly_eval.sv
module fpe_poly_eval
  import fpe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic              odd_exp_i,
  input  logic [FRAC_W-1:0] mant_i,
  output logic              valid_o,
  output logic [RES_W-1:0]  result_o
);
  logic [REG_W-1:0]  region;
  logic [ADDR_W-1:0] addr;
  coef_t             coef;
  logic              v1_q, neg1_q;
  logic [OFF_W-1:0]  x1_q;
  logic              v2, neg2;
  logic [Q1_W-1:0]   q1;
  logic [C0_W-1:0]   c0_2;
  logic [OFF_W-1:0]  x2;

  always_comb begin
    case (func_i)
      FN_SQRT:  region = odd_exp_i ? REG_W'(2) : REG_W'(1);
      FN_RSQRT: region = odd_exp_i ? REG_W'(4) : REG_W'(3);
      default:  region = REG_W'(0);
    endcase
  end

  assign addr = {region, mant_i[FRAC_W-1 -: IDX_W]};

  fpe_coef_rom u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .addr_i (addr),
    .data_o (coef)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v1_q <= 1'b0;
    else         v1_q <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      x1_q   <= mant_i[OFF_W-1:0];
      neg1_q <= (func_i != FN_SQRT);
    end
  end

  fpe_quad_mac u_quad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v1_q),
    .coef_i (coef),
    .x_i    (x1_q),
    .neg_i  (neg1_q),
    .v_o    (v2),
    .q1_o   (q1),
    .c0_o   (c0_2),
    .x_o    (x2),
    .neg_o  (neg2)
  );

  fpe_lin_mac u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v2),
    .q1_i   (q1),
    .c0_i   (c0_2),
    .x_i    (x2),
    .neg_i  (neg2),
    .v_o    (valid_o),
    .res_o  (result_o)
  );

  // edges since reset, saturating; only for the latency property
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 3'd4)  warm_q <= warm_q + 3'd1;
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

// File: tb/fpe_poly_eval_tb.sv
module fpe_poly_eval_tb;
  localparam int NMAX = 16384;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  func_i = '0;
  logic        odd_exp_i = 1'b0;
  logic [22:0] mant_i = '0;
  logic        valid_o;
  logic [27:0] result_o;

  always #10 clk = ~clk;

  fpe_poly_eval u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .func_i    (func_i),
    .odd_exp_i (odd_exp_i),
    .mant_i    (mant_i),
    .valid_o   (valid_o),
    .result_o  (result_o)
  );

  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  int          n = 0;
  int          rcv = 0;
  int          s_fn [NMAX];
  bit          s_odd [NMAX];
  int unsigned s_m [NMAX];
  int          s_cyc [NMAX];
  string       s_req [NMAX];
  int unsigned got [NMAX];
  int          got_cyc [NMAX];
  int unsigned last_res = 0;
  bit          have_res = 0;
  int          hold_bad = 0;
  int          hold_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (rcv < NMAX) begin
          got[rcv] = result_o;
          got_cyc[rcv] = cyc;
        end
        rcv++;
        last_res = result_o;
        have_res = 1;
      end else if (have_res) begin
        hold_seen++;
        if (result_o != last_res) hold_bad++;
      end
    end
  end

  task automatic chk_int(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(int fn, bit odd, int unsigned m, string req);
    @(negedge clk);
    valid_i = 1'b1;
    func_i = fn[1:0];
    odd_exp_i = odd;
    mant_i = m[22:0];
    s_fn[n] = fn;
    s_odd[n] = odd;
    s_m[n] = m & 32'h7FFFFF;
    s_cyc[n] = cyc;
    s_req[n] = req;
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      func_i = $urandom();
      odd_exp_i = $urandom();
      mant_i = $urandom();
    end
  endtask

  function automatic real ref_val(int fn, bit odd, int unsigned m);
    real x;
    x = 1.0 + $itor(m) / 8388608.0;
    if (fn == 1) return odd ? $sqrt(2.0 * x) : $sqrt(x);
    if (fn == 2) return odd ? 1.0 / $sqrt(2.0 * x) : 1.0 / $sqrt(x);
    return 1.0 / x;
  endfunction

  function automatic string fn_req(int fn);
    if (fn == 1) return "R4";
    if (fn == 2) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int trip_base;
    int one_base;
    real r, y, tol;
    tol = 2.0 ** -23;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk_int(valid_o == 1'b0, "R1", "valid_o in reset", valid_o, 0);
    chk_int(result_o == 28'd0, "R1", "result_o in reset", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_int(valid_o == 1'b0, "R1", "valid_o after reset", valid_o, 0);
    chk_int(result_o == 28'd0, "R1", "result_o after reset", result_o, 0);

    // R7: exact unit operands
    one_base = n;
    send(0, 0, 0, "R7");
    send(1, 0, 0, "R7");
    send(2, 0, 0, "R7");
    idle(2);

    // R6 and R3-R5: every segment of every region, at both ends and middle
    for (int reg_i = 0; reg_i < 5; reg_i++) begin
      int fn;
      bit odd;
      fn  = (reg_i == 0) ? 0 : (reg_i <= 2) ? 1 : 2;
      odd = (reg_i == 2) || (reg_i == 4);
      for (int s = 0; s < 128; s++) begin
        send(fn, odd, (s << 16), "R6");
        send(fn, odd, (s << 16) | 32'hFFFF, "R6");
        send(fn, odd, (s << 16) | 32'h8000, fn_req(fn));
        if ((s % 32) == 31) idle(3);
      end
    end

    // R8: parity and alias code leave reciprocal unchanged
    trip_base = n;
    for (int i = 0; i < 64; i++) begin
      int unsigned m;
      m = $urandom() & 32'h7FFFFF;
      send(0, 0, m, "R8");
      send(0, 1, m, "R8");
      send(3, 0, m, "R8");
    end
    idle(4);

    // mixed random stream with gaps (R2, R9)
    for (int i = 0; i < 6000; i++) begin
      int fn;
      fn = $urandom_range(0, 3);
      send(fn, 1'($urandom()), $urandom(), fn_req(fn));
      if ($urandom_range(0, 40) == 0) idle($urandom_range(1, 5));
    end
    idle(12);

    // checks
    chk_int(rcv == n, "R2", "result count", rcv, n);
    for (int i = 0; i < n && i < rcv; i++) begin
      chk_int(got_cyc[i] - s_cyc[i] == 4, "R2", "latency", got_cyc[i] - s_cyc[i], 4);
      r = ref_val(s_fn[i], s_odd[i], s_m[i]);
      y = $itor(got[i]) / 134217728.0;
      total++;
      if ((y - r > tol) || (r - y > tol)) begin
        bad++;
        $display("FAIL %s accuracy fn=%0d odd=%0d m=%h actual=%.10f expected=%.10f",
                 s_req[i], s_fn[i], s_odd[i], s_m[i], y, r);
      end
    end
    for (int i = 0; i < 3; i++)
      chk_int(got[one_base + i] == 32'h8000000, "R7", "unit operand", got[one_base + i], 32'h8000000);
    for (int i = 0; i < 64; i++) begin
      int b;
      b = trip_base + 3 * i;
      chk_int(got[b + 1] == got[b], "R8", "odd_exp_i on reciprocal", got[b + 1], got[b]);
      chk_int(got[b + 2] == got[b], "R8", "code 3 vs code 0", got[b + 2], got[b]);
    end
    chk_int(hold_seen > 0, "R9", "idle cycles observed", hold_seen, 1);
    chk_int(hold_bad == 0, "R9", "result changed while idle", hold_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule